// File: doc/BRIEF.md
# Inter-Block Command Packet Generator

This block lets one processing block in a streaming network-on-chip write a register in another block without a round trip through the host. A local request carries a 32-bit register address, 32-bit write data and an optional 64-bit execution time. The block turns it into a raw command packet on a 64-bit AXI4-Stream output: a generated header word, an optional timestamp word and one payload word. The header carries a routing ID that the block forms from a configured instance index.

Each command makes the receiver send back a response packet. This block sinks all of them, so the return path never backs up. It checks that the responses arrive in sequence and raises a sticky error flag if one does not. The receiver keeps timed commands in a queue that has no overflow protection. For that reason the block holds a credit count for that queue and stops taking requests when the count reaches zero.

Top module: `cmd_pkt_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the sequence counter clears to 0, credits return to `CMD_QUEUE_DEPTH`, the output goes idle (`m_tvalid`=0) and `seq_err` clears. After reset `req_ready`=1.
- R2: An accepted untimed request (`req_timed`=0) produces exactly two beats: the header, then the payload `{req_addr, req_data}` (address in bits 63:32). `m_tlast` is high only on the payload beat.
- R3: Header layout: [63:62]=2'b10, [61]=has-time flag, [60]=0, [59:48]=sequence number, [47:32]=byte length (16 untimed, 24 timed), [31:16]=`SRC_SID`, [15:0]=destination stream ID.
- R4: While `m_tvalid` is high and `m_tready` is low, `m_tvalid` stays high and `m_tdata`/`m_tlast` stay unchanged.
- R5: An accepted timed request produces three beats: the header with flag and length 24, then `req_time`, then the payload. `m_tlast` is high on the third beat only.
- R6: The destination stream ID is {8'h00, (`dst_inst` + `PORT_OFFSET`) mod 16, 4'h0}.
- R7: `ack_tready` is high in every cycle after reset.
- R8: Only one request is handled at a time. `req_ready` is low from the accepting edge until the edge at which the last beat is handed off.
- R9: Each accepted timed request uses one credit. `req_ready` is low for any request while no credit is left.
- R10: A response whose first beat has bit 61 set returns one credit. A response with bit 61 clear returns none.
- R11: The first beat of the n-th response since reset (counting from 0) must carry n mod 4096 in bits [59:48]. A mismatch sets `seq_err`, which stays set until `err_clear` is pulsed.
- R12: The sequence number in the header rises by one per accepted request, modulo 4096, starting from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken on this edge when valid |
| req_timed | input | 1 | Request carries an execution time |
| req_addr | input | 32 | Target register address |
| req_data | input | 32 | Data to write |
| req_time | input | 64 | Execution time for timed requests |
| dst_inst | input | 4 | Instance index of the target block |
| m_tdata | output | 64 | Command stream data |
| m_tvalid | output | 1 | Command stream valid |
| m_tready | input | 1 | Command stream ready |
| m_tlast | output | 1 | Last beat of a command packet |
| ack_tdata | input | 64 | Response stream data |
| ack_tvalid | input | 1 | Response stream valid |
| ack_tready | output | 1 | Response stream ready |
| ack_tlast | input | 1 | Last beat of a response packet |
| err_clear | input | 1 | Clears the sticky sequence error |
| seq_err | output | 1 | Sticky response-sequence mismatch |

## Verification
The bench stalls the header beat under backpressure. A design that let data move or dropped valid there would corrupt packets downstream. It uses up every credit with timed commands and then returns credits first with an untimed-flag response and then with a timed one. A design that counted every response, or never returned credits, would leave `req_ready` in the wrong state. It steps through all 16 instance indices to catch an offset that is missing or does not wrap. It runs more than 4096 commands to check that the sequence field wraps to zero. It sends a response with a bad sequence number and checks that the error flag is set, stays set, and clears only through `err_clear`.

// File: rtl/cmd_pkt_pkg.sv
// Shared types and header construction for the command packet generator.
// Assumes a 64-bit command stream and 16-bit stream IDs.
package cmd_pkt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_TIME = 2'd2,
        ST_PAY  = 2'd3
    } tx_state_e;

    localparam int HAS_TIME_BIT = 61;
    localparam int SEQ_LO       = 48;
    localparam int SEQ_W        = 12;

    // Builds one command header word from its fields.
    function automatic logic [63:0] make_hdr(input logic        timed,
                                             input logic [11:0] seq,
                                             input logic [15:0] src,
                                             input logic [15:0] dst);
        logic [15:0] len;
        len = timed ? 16'd24 : 16'd16;
        return {2'b10, timed, 1'b0, seq, len, src, dst};
    endfunction

endpackage

// File: rtl/cmd_tx_fsm.sv
// Command transmitter. It takes one request at a time, latches the request,
// and plays out header, optional time and payload on the stream. Assumes
// can_issue already reflects whether credit is available.
module cmd_tx_fsm
    import cmd_pkt_pkg::*;
#(
    parameter logic [15:0] SRC_SID = 16'h0020
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        can_issue,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_timed,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_data,
    input  logic [63:0] req_time,
    input  logic [15:0] dst_sid,
    output logic [63:0] m_tdata,
    output logic        m_tvalid,
    input  logic        m_tready,
    output logic        m_tlast,
    output logic        take_timed
);

    tx_state_e         state_q;
    logic [SEQ_W-1:0]  seq_q;
    logic [63:0]       hdr_q, time_q, pay_q;
    logic              timed_q;
    logic              accept, beat_done;

    assign req_ready  = (state_q == ST_IDLE) && can_issue;
    assign accept     = req_valid && req_ready;
    assign beat_done  = m_tvalid && m_tready;
    assign take_timed = accept && req_timed;

    // Output beat selection from the latched request.
    always_comb begin
        m_tvalid = (state_q != ST_IDLE);
        m_tlast  = (state_q == ST_PAY);
        case (state_q)
            ST_HDR:  m_tdata = hdr_q;
            ST_TIME: m_tdata = time_q;
            ST_PAY:  m_tdata = pay_q;
            default: m_tdata = '0;
        endcase
    end

    // Request latch, sequence counter and beat sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            seq_q   <= '0;
            hdr_q   <= '0;
            time_q  <= '0;
            pay_q   <= '0;
            timed_q <= 1'b0;
        end else if (accept) begin
            hdr_q   <= make_hdr(req_timed, seq_q, SRC_SID, dst_sid);
            time_q  <= req_time;
            pay_q   <= {req_addr, req_data};
            timed_q <= req_timed;
            seq_q   <= seq_q + 1'b1;
            state_q <= ST_HDR;
        end else if (beat_done) begin
            case (state_q)
                ST_HDR:  state_q <= timed_q ? ST_TIME : ST_PAY;
                ST_TIME: state_q <= ST_PAY;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R4: a stalled beat keeps its value
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

    // R12: each acceptance advances the sequence by one
    a_r12_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (seq_q == $past(seq_q) + 1'b1));

    // R8: no acceptance while a packet is in flight
    a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid && !(m_tlast && m_tready)) |=> !accept);

endmodule

// File: rtl/cmd_credit.sv
// Credit counter for the receiver's timed-command queue. It starts full,
// decrements on each timed issue and increments on each timed response.
// Assumes take is raised only while avail is high.
module cmd_credit #(
    parameter int CMD_QUEUE_DEPTH = 4,
    localparam int CW = $clog2(CMD_QUEUE_DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic give,
    output logic avail
);

    logic [CW-1:0] cnt_q;
    localparam logic [CW-1:0] FULL = CW'(CMD_QUEUE_DEPTH);

    assign avail = (cnt_q != '0);

    // Credit update; a return that would pass full saturates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= FULL;
        end else if (take && !give) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (give && !take && cnt_q != FULL) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the count never exceeds the queue depth
    a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL);

    // R9: no credit is taken from an empty counter
    a_r9_no_take_empty: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> (cnt_q != '0));

endmodule

// File: rtl/ack_drain.sv
// Response sink. It is always ready, checks the sequence number in each
// response header and signals a credit for responses that carry the time flag.
// Assumes responses return in issue order.
module ack_drain
    import cmd_pkt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] ack_tdata,
    input  logic        ack_tvalid,
    input  logic        ack_tlast,
    output logic        ack_tready,
    input  logic        err_clear,
    output logic        seq_err,
    output logic        credit_ret
);

    logic              first_q;
    logic [SEQ_W-1:0]  exp_q;
    logic              hdr_beat, mismatch;
    logic              ack_unused;

    assign ack_tready = rst_n;
    assign hdr_beat   = ack_tvalid && first_q && rst_n;
    assign mismatch   = hdr_beat && (ack_tdata[SEQ_LO +: SEQ_W] != exp_q);
    assign credit_ret = hdr_beat && ack_tdata[HAS_TIME_BIT];
    assign ack_unused = ^{ack_tdata[63:62], ack_tdata[60], ack_tdata[47:0]};

    // Packet framing and expected sequence tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            exp_q   <= '0;
        end else if (ack_tvalid) begin
            first_q <= ack_tlast;
            if (first_q) exp_q <= exp_q + 1'b1;
        end
    end

    // Sticky error; a new mismatch wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         seq_err <= 1'b0;
        else if (mismatch)  seq_err <= 1'b1;
        else if (err_clear) seq_err <= 1'b0;
    end

    // R7: the response path is never stalled
    a_r7_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ack_tready);

    // R11: the error stays set until cleared
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !err_clear) |=> seq_err);

    // R11: a clear without a new mismatch drops the flag
    a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !mismatch) |=> !seq_err);

endmodule

// File: rtl/cmd_pkt_gen.sv
// Inter-block command packet generator top. It routes a local register-write
// request to another block as a raw command packet, tracks timed-queue
// credits and drains responses. Assumes one response per command, in order.
module cmd_pkt_gen #(
    parameter int          CMD_QUEUE_DEPTH = 4,
    parameter int          PORT_OFFSET     = 5,
    parameter logic [15:0] SRC_SID         = 16'h0020
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_timed,
    input  logic [31:0] req_addr,
    input  logic [31:0] req_data,
    input  logic [63:0] req_time,
    input  logic [3:0]  dst_inst,
    output logic [63:0] m_tdata,
    output logic        m_tvalid,
    input  logic        m_tready,
    output logic        m_tlast,
    input  logic [63:0] ack_tdata,
    input  logic        ack_tvalid,
    output logic        ack_tready,
    input  logic        ack_tlast,
    input  logic        err_clear,
    output logic        seq_err
);

    localparam logic [3:0] OFF4 = 4'(PORT_OFFSET);

    logic [3:0]  xbar_port;
    logic [15:0] dst_sid;
    logic        can_issue, take_timed, credit_ret;

    // Destination routing ID from the target's instance index.
    assign xbar_port = dst_inst + OFF4;
    assign dst_sid   = {8'h00, xbar_port, 4'h0};

    cmd_tx_fsm #(.SRC_SID(SRC_SID)) u_tx (
        .clk(clk), .rst_n(rst_n), .can_issue(can_issue),
        .req_valid(req_valid), .req_ready(req_ready), .req_timed(req_timed),
        .req_addr(req_addr), .req_data(req_data), .req_time(req_time),
        .dst_sid(dst_sid), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
        .m_tready(m_tready), .m_tlast(m_tlast), .take_timed(take_timed)
    );

    cmd_credit #(.CMD_QUEUE_DEPTH(CMD_QUEUE_DEPTH)) u_credit (
        .clk(clk), .rst_n(rst_n), .take(take_timed), .give(credit_ret),
        .avail(can_issue)
    );

    ack_drain u_drain (
        .clk(clk), .rst_n(rst_n), .ack_tdata(ack_tdata), .ack_tvalid(ack_tvalid),
        .ack_tlast(ack_tlast), .ack_tready(ack_tready), .err_clear(err_clear),
        .seq_err(seq_err), .credit_ret(credit_ret)
    );

    // R1: output is idle in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !m_tvalid);

endmodule

// File: tb/test_cmd_pkt_gen.sv
// Self-checking bench: directed cases plus sweeps over instance index and
// the full sequence-number range.
module test_cmd_pkt_gen;

    localparam int          DEPTH = 4;
    localparam int          OFFS  = 5;
    localparam logic [15:0] SRC   = 16'h0020;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_timed = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0, req_data = '0;
    logic [63:0] req_time = '0;
    logic [3:0]  dst_inst = '0;
    logic [63:0] m_tdata;
    logic        m_tvalid, m_tlast;
    logic        m_tready = 1'b1;
    logic [63:0] ack_tdata = '0;
    logic        ack_tvalid = 1'b0, ack_tlast = 1'b0;
    logic        ack_tready;
    logic        err_clear = 1'b0;
    logic        seq_err;

    int compared = 0;
    int mismatched = 0;
    logic [11:0] tx_seq = '0;
    logic [11:0] rsp_seq = '0;

    always #10 clk = ~clk;

    cmd_pkt_gen #(.CMD_QUEUE_DEPTH(DEPTH), .PORT_OFFSET(OFFS), .SRC_SID(SRC)) i_cmd_pkt_gen (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_timed(req_timed), .req_addr(req_addr), .req_data(req_data),
        .req_time(req_time), .dst_inst(dst_inst), .m_tdata(m_tdata),
        .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast),
        .ack_tdata(ack_tdata), .ack_tvalid(ack_tvalid), .ack_tready(ack_tready),
        .ack_tlast(ack_tlast), .err_clear(err_clear), .seq_err(seq_err)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_hdr(input logic timed, input logic [11:0] seq, input logic [3:0] inst);
        logic [3:0] port;
        port = 4'((32'(inst) + OFFS) % 16);
        return {2'b10, timed, 1'b0, seq, (timed ? 16'd24 : 16'd16), SRC, 8'h00, port, 4'h0};
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        tx_seq = '0; rsp_seq = '0;
        @(negedge clk);
    endtask

    // Issue one command and compare every beat (R2 R3 R4 R5 R8 R12).
    task automatic do_cmd(input logic timed, input logic [31:0] a, input logic [31:0] d,
                          input logic [63:0] t, input logic [3:0] inst, input int stall,
                          input string tag);
        int nb;
        logic [63:0] ev;
        req_valid = 1'b1; req_timed = timed; req_addr = a; req_data = d;
        req_time = t; dst_inst = inst; m_tready = (stall == 0);
        while (!req_ready) @(negedge clk);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        nb = timed ? 3 : 2;
        for (int b = 0; b < nb; b++) begin
            ev = (b == 0) ? exp_hdr(timed, tx_seq, inst) : ((timed && b == 1) ? t : {a, d});
            if (b == 0) begin
                for (int s = 0; s < stall; s++) begin
                    chk(m_tvalid && m_tdata == ev && !m_tlast, "R4 stalled beat held", m_tdata, ev);
                    @(negedge clk);
                end
            end
            chk(m_tvalid && m_tdata == ev, {tag, " beat data"}, m_tdata, ev);
            chk(m_tlast == (b == nb - 1), {tag, " tlast placement"}, 64'(m_tlast), 64'(b == nb - 1));
            chk(!req_ready, "R8 not ready while busy", 64'(req_ready), 64'd0);
            m_tready = 1'b1;
            @(posedge clk); @(negedge clk);
        end
        chk(!m_tvalid, {tag, " idle after packet"}, 64'(m_tvalid), 64'd0);
        tx_seq = tx_seq + 1'b1;
    endtask

    task automatic send_rsp(input logic [11:0] seq, input logic timed);
        ack_tvalid = 1'b1; ack_tlast = 1'b0;
        ack_tdata = {2'b11, timed, 1'b0, seq, 16'd16, 16'h0050, SRC};
        @(posedge clk); @(negedge clk);
        ack_tlast = 1'b1; ack_tdata = 64'h0000_0000_dead_beef;
        @(posedge clk); @(negedge clk);
        ack_tvalid = 1'b0; ack_tlast = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++; compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state, R7 response ready
        chk(req_ready, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk(!m_tvalid, "R1 idle after reset", 64'(m_tvalid), 64'd0);
        chk(!seq_err, "R1 error clear after reset", 64'(seq_err), 64'd0);
        chk(ack_tready, "R7 response ready", 64'(ack_tready), 64'd1);

        // R2 R3 R4 untimed with a stalled header
        do_cmd(1'b0, 32'h0000_0104, 32'hcafe_0001, 64'h0, 4'd2, 3, "R2 R3 untimed");
        // R5 timed
        do_cmd(1'b1, 32'h0000_0200, 32'h1234_5678, 64'h0000_0012_3456_789a, 4'd3, 0, "R5 timed");
        do_cmd(1'b1, 32'hffff_fffc, 32'h0, 64'hffff_ffff_ffff_ffff, 4'd0, 1, "R5 timed stall");

        // R6 sweep over every instance index, incl. port wrap
        for (int i = 0; i < 16; i++)
            do_cmd(1'b0, 32'(i), ~32'(i), 64'h0, 4'(i), 0, "R6 dst sweep");

        // R11 in-order responses raise no error, R7 ready throughout
        for (int i = 0; i < 19; i++) begin
            send_rsp(rsp_seq, 1'b0);
            rsp_seq = rsp_seq + 1'b1;
            chk(ack_tready, "R7 response ready", 64'(ack_tready), 64'd1);
        end
        chk(!seq_err, "R11 in-order no error", 64'(seq_err), 64'd0);

        // R1 reset restores credits; R9 exhaust credits
        do_reset();
        for (int i = 0; i < DEPTH; i++)
            do_cmd(1'b1, 32'h40 + 32'(i), 32'(i), 64'(i) + 64'd100, 4'd1, 0, "R9 timed issue");
        chk(!req_ready, "R9 ready low at zero credit", 64'(req_ready), 64'd0);
        // R10 untimed-flag response returns no credit
        send_rsp(rsp_seq, 1'b0); rsp_seq = rsp_seq + 1'b1;
        chk(!req_ready, "R10 untimed response no credit", 64'(req_ready), 64'd0);
        // R10 timed-flag response returns a credit
        send_rsp(rsp_seq, 1'b1); rsp_seq = rsp_seq + 1'b1;
        chk(req_ready, "R10 timed response returns credit", 64'(req_ready), 64'd1);
        chk(!seq_err, "R11 no error in order", 64'(seq_err), 64'd0);
        do_cmd(1'b1, 32'h80, 32'h1, 64'd7, 4'd9, 0, "R9 issue with returned credit");
        chk(!req_ready, "R9 credit used again", 64'(req_ready), 64'd0);

        // R11 mismatch, sticky, clear
        send_rsp(12'd99, 1'b0); rsp_seq = rsp_seq + 1'b1;
        chk(seq_err, "R11 mismatch sets error", 64'(seq_err), 64'd1);
        send_rsp(rsp_seq, 1'b0); rsp_seq = rsp_seq + 1'b1;
        chk(seq_err, "R11 error sticky", 64'(seq_err), 64'd1);
        err_clear = 1'b1; @(posedge clk); @(negedge clk); err_clear = 1'b0;
        chk(!seq_err, "R11 clear drops error", 64'(seq_err), 64'd0);

        // R12 full sequence range plus wrap
        do_reset();
        for (int i = 0; i < 4100; i++)
            do_cmd(1'b0, 32'(i), 32'(i * 3), 64'h0, 4'(i), 0, "R12 sequence sweep");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule